// File: doc/BRIEF.md
# Fall-Armed B Follower

This block drives one output from two inputs, a qualifier and a data line. By default the output sits high. If the data line falls while the qualifier is high, the block arms. While armed, the output copies the data line exactly. The block disarms when it sees the qualifier and the data line high in the same cycle, and the output then returns to its default high level.

Both inputs must already be in the clock domain. At most one of them changes per clock cycle. The output is the data line ORed with a hold term. A change on the data line therefore reaches the output in the same cycle through one gate level, with no register on that path. The design uses two state bits:

- a registered copy of the data line, used to find its falling edge;
- an armed flag.

Top module: `trk_latch`

## Requirements
- R1: When `a_in` and `b_in` are both 1 in a cycle, `x_out` is 1 in that cycle. The armed state is then cleared, so in the next cycle with `a_in` at 0, `x_out` is 1.
- R2: A falling edge of `b_in` means `b_in` was 1 at the previous rising clock edge and is 0 now. If this happens while `a_in` is 1, `x_out` goes to 0 in that same cycle with no clock delay, and the block is armed from the next edge on.
- R3: While armed, `x_out` equals `b_in` in every cycle until `a_in` and `b_in` are both 1. This holds even when `b_in` rises and falls again with `a_in` at 0.
- R4: A falling edge of `b_in` while `a_in` is 0 and the block is not armed leaves `x_out` at 1 and does not arm the block.
- R5: Whenever `b_in` is 1, `x_out` is 1.
- R6: While `rst_n` is 0, the block is disarmed and `x_out` is 1 for any input values. The edge register clears to 0, so a `b_in` value held during reset never counts as a falling edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 1 | Qualifier sampled when `b_in` falls |
| b_in | input | 1 | Data line that `x_out` follows while armed |
| x_out | output | 1 | `b_in` ORed with the hold term |

## Verification
The assertions check these properties on every cycle:

- the output is high whenever the data line is high;
- a qualified fall drives the output low at once and arms the block;
- an unqualified fall, with the block disarmed, keeps the output high;
- while armed, the output equals the data line;
- the cycle after a coincidence, with the qualifier low, gives a high output.

Only the bench's scenarios show that the whole sequence of states matches the history-based definition. The bench runs every legal input path of eight cycles from each starting pair. This covers the re-entry into armed mode, a pulse on the data line with the qualifier low while armed, and the state at reset release.

// File: rtl/trk_pkg.sv
package trk_pkg;

    typedef struct packed {
        logic b_last;
    } edge_st_t;

    typedef struct packed {
        logic armed;
    } flag_st_t;

endpackage

// File: rtl/trk_edge_det.sv
module trk_edge_det
    import trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic b_in,
    output logic b_fall
);
    edge_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.b_last = b_in;
        b_fall      = st_q.b_last & ~b_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/trk_mode_flag.sv
module trk_mode_flag
    import trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_in,
    input  logic b_in,
    input  logic b_fall,
    output logic arm_now,
    output logic armed
);
    flag_st_t st_d, st_q;
    logic     coinc;

    always_comb begin
        st_d    = st_q;
        coinc   = a_in & b_in;
        arm_now = b_fall & a_in;
        if (coinc)        st_d.armed = 1'b0;
        else if (arm_now) st_d.armed = 1'b1;
        armed   = st_q.armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/trk_out_or.sv
module trk_out_or (
    input  logic b_in,
    input  logic armed,
    input  logic arm_now,
    output logic x_out
);
    logic hold;

    always_comb begin
        hold  = ~(armed | arm_now);
        x_out = b_in | hold;
    end
endmodule

// File: rtl/trk_latch.sv
module trk_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic a_in,
    input  logic b_in,
    output logic x_out
);
    logic fall_w;
    logic arm_now_w;
    logic trk_w;

    trk_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .b_in   (b_in),
        .b_fall (fall_w)
    );

    trk_mode_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_in    (a_in),
        .b_in    (b_in),
        .b_fall  (fall_w),
        .arm_now (arm_now_w),
        .armed   (trk_w)
    );

    trk_out_or u_or (
        .b_in    (b_in),
        .armed   (trk_w),
        .arm_now (arm_now_w),
        .x_out   (x_out)
    );
endmodule

// File: rtl/trk_latch_chk.sv
module trk_latch_chk (
    input logic clk,
    input logic rst_n,
    input logic a_in,
    input logic b_in,
    input logic x_out,
    input logic trk
);
    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_B_HIGH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        b_in |-> x_out); // R5

    AST_QUAL_FALL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $fell(b_in) && a_in) |-> (!x_out ##1 trk)); // R2

    AST_UNQUAL_FALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !trk && $fell(b_in) && !a_in) |-> x_out); // R4

    AST_ARMED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        trk |-> (x_out == b_in)); // R3

    AST_COINC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(a_in && b_in) && !a_in) |-> x_out); // R1
endmodule

bind trk_latch trk_latch_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a_in  (a_in),
    .b_in  (b_in),
    .x_out (x_out),
    .trk   (trk_w)
);

// File: tb/trk_latch_bench.sv
module trk_latch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS      = 7;
    localparam int PATHS      = 2187;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_in = 1'b0;
    logic b_in = 1'b0;
    logic x_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic m_prevb;
    logic m_fell;

    always #(CLK_PERIOD/2) clk = ~clk;

    trk_latch u_trk_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .a_in  (a_in),
        .b_in  (b_in),
        .x_out (x_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: x_out=%b expected %b (a=%b b=%b)", req, act, exp, a_in, b_in);
        end
    endtask

    task automatic do_reset(input logic na, input logic nb);
        @(negedge clk);
        rst_n = 1'b0;
        a_in = na;
        b_in = nb;
        #1;
        chk("R6", x_out, 1'b1);
        @(negedge clk);
        #1;
        chk("R6", x_out, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        m_prevb = 1'b0;
        m_fell  = 1'b0;
    endtask

    task automatic step(input logic na, input logic nb, input string tag);
        logic fall;
        logic expx;
        string req;
        @(negedge clk);
        a_in = na;
        b_in = nb;
        #1;
        fall = m_prevb && !nb;
        if (na && nb)        m_fell = 1'b0;
        else if (fall && na) m_fell = 1'b1;
        expx = nb || !m_fell;
        if (tag != "")        req = tag;
        else if (na && nb)    req = "R1";
        else if (nb)          req = "R5";
        else if (fall && na)  req = "R2";
        else if (m_fell)      req = "R3";
        else                  req = "R4";
        chk(req, x_out, expx);
        m_prevb = nb;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R6: B held high with A high through reset, no fall seen after release
        do_reset(1'b1, 1'b1);
        step(1'b1, 1'b1, "R6");
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b0, "R4");
        // R2 then R3 pitfall: B pulses with A low while armed, must keep following
        step(1'b1, 1'b0, "");
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R3");
        step(1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");

        // near-exhaustive: each cycle holds, toggles A, or toggles B
        for (int s0 = 0; s0 < 4; s0++) begin
            for (int code = 0; code < PATHS; code++) begin
                logic ca;
                logic cb;
                int c;
                ca = s0[1];
                cb = s0[0];
                c  = code;
                do_reset(ca, cb);
                step(ca, cb, "");
                for (int k = 0; k < STEPS; k++) begin
                    if (c % 3 == 1)      ca = !ca;
                    else if (c % 3 == 2) cb = !cb;
                    c = c / 3;
                    step(ca, cb, "");
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule